// File: doc/BRIEF.md
# Power Event Status Tracker

This block sits in a root port and keeps a 32-bit status word for power-management event messages that arrive from downstream requesters. It shows software one event at a time, together with the 16-bit ID of the requester that sent it. Events that arrive while an earlier one is still unacknowledged are held in a small first-in-first-out queue.

Software acknowledges the current event by writing a 1 to the status bit. If an event is being held, the block shows it on the next clock edge: the status bit is set again, the ID field is reloaded, and the pending bit drops once the queue is empty. The status bit is also driven out directly as an interrupt-style flag.

Top module: `pme_status_tracker`

## Requirements
- R1: After reset, and after any later reset, the read word is 0x00000000 and `pme_flag_o` is 0.
- R2: Bits 31:18 always read 0. Writes to bits 31:18, bit 17 and bits 15:0 have no effect on the read word.
- R3: An event that arrives while status (bit 16) is 0 sets status. From the next clock edge on, bits 15:0 show its requester ID, and `pme_flag_o` follows bit 16.
- R4: A write with bit 16 = 1 clears status on the next edge when no event is held and none arrives. A write with bit 16 = 0 leaves status unchanged.
- R5: An event that arrives while status is 1 is held. Status and the ID stay as they are, and bit 17 (pending) reads 1.
- R6: A clearing write while events are held makes the next read show status 1 and the oldest held ID. Held events are shown in arrival order.
- R7: Bit 17 reads 1 exactly when status is 1 and at least one event is held. It returns to 0 when the last held event is shown.
- R8: At most 4 events are held. An event that arrives while the queue is full and nothing leaves it in that cycle is dropped and never shown, and an internal sticky overflow marker is set.
- R9: An event that arrives in the same cycle as a clearing write, with the queue empty, is shown directly on the next edge.
- R10: An event that arrives in the same cycle as a clearing write, with events held, goes to the back of the queue. This also holds when the queue is full, because one entry leaves in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One-cycle strobe: a power event arrived |
| evt_rid_i | input | 16 | Requester ID of the arriving event |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data; only bit 16 is acted on (write 1 to clear) |
| reg_rdata_o | output | 32 | Register read data |
| pme_flag_o | output | 1 | Copy of the status bit |

## Verification
The hardest case to reach is a full queue in the same cycle as a clearing write and a new event. One entry leaves and one enters, so no event should be dropped. The stimulus gets there by raising status and then sending four events while status stays set. It then sends a fifth event, which must be lost. Finally it issues a clear together with a sixth event and acknowledges every redelivered ID in turn. This shows that the fifth event never appears and that the sixth comes out last.

// File: rtl/pme_stat_pkg.sv
package pme_stat_pkg;
  localparam int unsigned RID_W    = 16;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned STS_BIT  = RID_W;
  localparam int unsigned PEND_BIT = RID_W + 1;

  typedef logic [RID_W-1:0] rid_t;
  typedef logic [REG_W-1:0] reg_word_t;

  function automatic reg_word_t pack_word(logic pend, logic sts, rid_t rid);
    reg_word_t w;
    w = '0;
    w[RID_W-1:0] = rid;
    w[STS_BIT]   = sts;
    w[PEND_BIT]  = pend;
    return w;
  endfunction
endpackage

// File: rtl/pme_hold_fifo.sv
module pme_hold_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr == PTR_W'(i)) mem[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign valid_o = (count != '0);
  assign full_o  = (count == FULL_CNT);

  // R8: never written beyond capacity, never read empty
  a_r8_no_overfill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
endmodule

// File: rtl/pme_present_reg.sv
module pme_present_reg
  import pme_stat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_valid_i,
  input  rid_t evt_rid_i,
  input  logic clr_i,
  input  logic hold_valid_i,
  input  logic hold_full_i,
  input  rid_t hold_rid_i,
  output logic status_o,
  output rid_t rid_o,
  output logic pop_o,
  output logic push_o,
  output logic drop_o
);
  logic take_direct, hold_req;

  assign pop_o       = clr_i & hold_valid_i;
  assign take_direct = evt_valid_i & (~status_o | (clr_i & ~hold_valid_i));
  assign hold_req    = evt_valid_i & ~take_direct;
  assign push_o      = hold_req & (~hold_full_i | pop_o);
  assign drop_o      = hold_req & hold_full_i & ~pop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
      rid_o    <= '0;
    end else if (pop_o) begin
      status_o <= 1'b1;
      rid_o    <= hold_rid_i;
    end else if (take_direct) begin
      status_o <= 1'b1;
      rid_o    <= evt_rid_i;
    end else if (clr_i) begin
      status_o <= 1'b0;
    end
  end

  a_r3_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !status_o) |=> (status_o && rid_o == $past(evt_rid_i)));
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_i) |=> (status_o && $stable(rid_o)));
  a_r6_redeliver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hold_valid_i) |=> (status_o && rid_o == $past(hold_rid_i)));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hold_valid_i && !evt_valid_i) |=> !status_o);
endmodule

// File: rtl/pme_status_tracker.sv
module pme_status_tracker
  import pme_stat_pkg::*;
#(
  parameter int unsigned HOLD_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [RID_W-1:0]  evt_rid_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              pme_flag_o
);
  logic status, clr, pop, push, drop, hold_valid, hold_full, pending, ovf_q;
  rid_t rid, hold_rid;

  assign clr = reg_we_i & reg_wdata_i[STS_BIT] & status;

  pme_present_reg u_present (
    .clk_i, .rst_ni,
    .evt_valid_i, .evt_rid_i,
    .clr_i(clr),
    .hold_valid_i(hold_valid), .hold_full_i(hold_full), .hold_rid_i(hold_rid),
    .status_o(status), .rid_o(rid),
    .pop_o(pop), .push_o(push), .drop_o(drop)
  );

  pme_hold_fifo #(.DEPTH(HOLD_DEPTH), .W(RID_W)) u_hold (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(evt_rid_i), .pop_i(pop),
    .head_o(hold_rid), .valid_o(hold_valid), .full_o(hold_full)
  );

  // sticky loss marker, internal only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign pending     = status & hold_valid;
  assign reg_rdata_o = pack_word(pending, status, rid);
  assign pme_flag_o  = status;

  a_r7_pending_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[PEND_BIT] |-> reg_rdata_o[STS_BIT]);
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r2_ro_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wdata_i[STS_BIT] && !evt_valid_i) |=> $stable(reg_rdata_o));
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:PEND_BIT+1] == '0);
endmodule

// File: tb/pme_status_tracker_bench.sv
module pme_status_tracker_bench;
  typedef struct packed {
    logic [31:0] tag;
    logic        we;
    logic [31:0] wd;
    logic        ev;
    logic [15:0] rid;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{"R1  ", 1'b0, 32'h0,         1'b0, 16'h0,    32'h0000_0000}, // idle
    '{"R3  ", 1'b0, 32'h0,         1'b1, 16'h1111, 32'h0001_1111},
    '{"R5  ", 1'b0, 32'h0,         1'b1, 16'h2222, 32'h0003_1111},
    '{"R4  ", 1'b1, 32'h0,         1'b0, 16'h0,    32'h0003_1111}, // write 0
    '{"R2  ", 1'b1, 32'hFFFE_FFFF, 1'b0, 16'h0,    32'h0003_1111}, // ro/reserved
    '{"R5  ", 1'b0, 32'h0,         1'b1, 16'h3333, 32'h0003_1111},
    '{"R6  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0003_2222},
    '{"R7  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0001_3333},
    '{"R4  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0000_3333},
    '{"R4  ", 1'b1, 32'hFFFF_FFFF, 1'b0, 16'h0,    32'h0000_3333}, // clear when idle
    '{"R3  ", 1'b0, 32'h0,         1'b1, 16'h4444, 32'h0001_4444},
    '{"R9  ", 1'b1, 32'h0001_0000, 1'b1, 16'h5555, 32'h0001_5555},
    '{"R5  ", 1'b0, 32'h0,         1'b1, 16'hA001, 32'h0003_5555},
    '{"R5  ", 1'b0, 32'h0,         1'b1, 16'hA002, 32'h0003_5555},
    '{"R5  ", 1'b0, 32'h0,         1'b1, 16'hA003, 32'h0003_5555},
    '{"R8  ", 1'b0, 32'h0,         1'b1, 16'hA004, 32'h0003_5555}, // queue full
    '{"R8  ", 1'b0, 32'h0,         1'b1, 16'hA005, 32'h0003_5555}, // dropped
    '{"R10 ", 1'b1, 32'h0001_0000, 1'b1, 16'hB000, 32'h0003_A001},
    '{"R6  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0003_A002},
    '{"R6  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0003_A003},
    '{"R6  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0003_A004},
    '{"R10 ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0001_B000}, // no A005
    '{"R7  ", 1'b1, 32'h0001_0000, 1'b0, 16'h0,    32'h0000_B000},
    '{"R9  ", 1'b0, 32'h0,         1'b1, 16'hC000, 32'h0001_C000},
    '{"R10 ", 1'b0, 32'h0,         1'b1, 16'hC001, 32'h0003_C000},
    '{"R10 ", 1'b1, 32'h0001_0000, 1'b1, 16'hC002, 32'h0003_C001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_v = 1'b0;
  logic [15:0] evt_rid = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        flag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pme_status_tracker u_pme_status_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_v), .evt_rid_i(evt_rid),
    .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .pme_flag_o(flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [31:0] d, logic e, logic [15:0] r);
    @(negedge clk);
    we = w; wd = d; evt_v = e; evt_rid = r;
    @(posedge clk);
    #1;
    @(negedge clk);
    we = 1'b0; wd = '0; evt_v = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rdata, 32'h0);
    chk("R1", {31'b0, flag}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].we; wd = VECS[i].wd; evt_v = VECS[i].ev; evt_rid = VECS[i].rid;
      @(posedge clk);
      #1;
      chk(string'(VECS[i].tag), rdata, VECS[i].exp);
      chk("R3", {31'b0, flag}, {31'b0, VECS[i].exp[16]});
    end
    @(negedge clk);
    we = 1'b0; evt_v = 1'b0;
    // R1: reset in the middle of activity, with events held
    rst_n = 1'b0;
    #2;
    chk("R1", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: nothing held survives reset
    step(1'b0, 32'h0, 1'b1, 16'hD00D);
    chk("R7", rdata, 32'h0001_D00D);
    step(1'b1, 32'h0001_0000, 1'b0, 16'h0);
    chk("R7", rdata, 32'h0000_D00D);
    // R2: write all ones except status while held
    step(1'b0, 32'h0, 1'b1, 16'hE001);
    step(1'b0, 32'h0, 1'b1, 16'hE002);
    step(1'b1, 32'hFFFE_FFFF, 1'b0, 16'h0);
    chk("R2", rdata, 32'h0003_E001);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule